// File: doc/BRIEF.md
# Shared-Memory Mailbox With Hold Lock

This block is a register-mapped mailbox between a host function and an embedded firmware side. Each side has its own synchronous register port (word address, write enable, write data, registered read data) onto one common map: a firmware-to-host counter word, a host-to-firmware counter word, a shared message buffer, one control register per side and an interrupt mask register.

A side takes the mailbox by writing the hold bit of its own control register and reading the register back. The bit only sets when the other side does not hold the lock, so a readback of 0 means the attempt failed. Only the holder may write the buffer. Setting the request bit in a control register raises a one-cycle event toward the other side, gated by the mask. A host write to the first buffer word marks the buffer as consumed for the firmware. A mailbox reset command clears the counters and the control registers and reloads the mask.

Word map (word address): 0 firmware-to-host counter, 1 host-to-firmware counter, 2 to 15 buffer, 16 host control, 17 firmware control, 18 interrupt mask. Control layout: bit 0 request, bit 3 hold.

Top module: `shm_mailbox`

## Requirements
- R1: After rst_n, both counters, both control registers and every buffer word read 0, the mask reads 0xFFFF0000, and fw_irq, host_irq and buf_consumed are low.
- R2: A write of bit 3 to a side's own control register (host word 16, firmware word 17) sets its hold bit when the other side does not hold; a later write of 0 clears both hold (bit 3) and request (bit 0).
- R3: At most one side holds. A hold write while the other side holds is ignored and reads back 0. When both sides request hold in the same cycle from the free state, the host wins.
- R4: Word 0 (request count in bits 15:0, acknowledge count in bits 31:16) is written only by the firmware port and word 1 (same layout) only by the host port; writes from the other port are ignored. Both ports can read both words.
- R5: Buffer words 2 to 15 take a write only from the side that holds the lock; other writes are ignored. Either port can read any word at any time.
- R6: A host control write with bit 0 set drives fw_irq high for exactly the following cycle unless mask bit 0 is 1; a firmware control write with bit 0 set drives host_irq likewise unless mask bit 16 is 1. The mask (word 18) is written by the host port only.
- R7: An accepted host write to word 2 sets buf_consumed; host writes to other buffer words leave it unchanged; the next accepted firmware buffer write clears it.
- R8: The mbx_clr command zeroes both counters and both control registers, reloads the mask with 0xFFFF0000, clears buf_consumed and leaves the buffer contents intact.
- R9: Read data appears in the cycle after the address is presented; addresses above 18 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbx_clr | input | 1 | Mailbox reset command |
| h_we | input | 1 | Host write enable |
| h_addr | input | 5 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after the address |
| f_we | input | 1 | Firmware write enable |
| f_addr | input | 5 | Firmware word address |
| f_wdata | input | 32 | Firmware write data |
| f_rdata | output | 32 | Firmware read data, one cycle after the address |
| fw_irq | output | 1 | Host request event toward the firmware, masked by bit 0 |
| host_irq | output | 1 | Firmware request event toward the host, masked by bit 16 |
| buf_consumed | output | 1 | Host has marked the buffer as read |

## Verification
The assertions take it as given that mbx_clr is not asserted in the same cycle as a write whose effect they check, and that a control write and a mask write never come from the host port in one cycle, which its single address makes impossible anyway. The stimulus drives mbx_clr only in a quiet cycle and changes inputs on the falling edge, so each accepted write lands on exactly one rising edge. The bench sweeps every buffer word under each owner state (free, host holding, firmware holding) from both ports and drives both hold bits in the same cycle to exercise the tie.

// File: rtl/shm_mailbox.sv
module shm_mailbox #(
  parameter int          BUF_WORDS = 14,
  parameter logic [31:0] MASK_INIT = 32'hFFFF_0000,
  parameter int          AW        = $clog2(BUF_WORDS + 5)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mbx_clr,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  input  logic          f_we,
  input  logic [AW-1:0] f_addr,
  input  logic [31:0]   f_wdata,
  output logic [31:0]   f_rdata,
  output logic          fw_irq,
  output logic          host_irq,
  output logic          buf_consumed
);
  localparam int BUF0   = 2;
  localparam int CTL_H  = BUF0 + BUF_WORDS;
  localparam int CTL_F  = CTL_H + 1;
  localparam int MASK_A = CTL_F + 1;

  logic [31:0] cnt_f2h, cnt_h2f, irq_mask;
  logic [31:0] buf_q [BUF_WORDS];
  logic        h_hold, h_req, f_hold, f_req, h_evt, f_evt;
  logic [31:0] ha, fa;
  logic        h_ctl_wr, f_ctl_wr, h_grab, f_grab, f_buf_wr;

  assign ha       = 32'(h_addr);
  assign fa       = 32'(f_addr);
  assign h_ctl_wr = h_we && ha == CTL_H;
  assign f_ctl_wr = f_we && fa == CTL_F;
  assign h_grab   = h_ctl_wr && h_wdata[3] && !f_hold;
  assign f_grab   = f_ctl_wr && f_wdata[3] && !h_hold && !h_grab;
  assign f_buf_wr = f_we && f_hold && fa >= BUF0 && fa < CTL_H;

  assign fw_irq   = h_evt && !irq_mask[0];
  assign host_irq = f_evt && !irq_mask[16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_f2h <= '0; cnt_h2f <= '0; irq_mask <= MASK_INIT;
      h_hold <= 1'b0; h_req <= 1'b0; f_hold <= 1'b0; f_req <= 1'b0;
      h_evt <= 1'b0; f_evt <= 1'b0; buf_consumed <= 1'b0;
    end else if (mbx_clr) begin
      cnt_f2h <= '0; cnt_h2f <= '0; irq_mask <= MASK_INIT;
      h_hold <= 1'b0; h_req <= 1'b0; f_hold <= 1'b0; f_req <= 1'b0;
      h_evt <= 1'b0; f_evt <= 1'b0; buf_consumed <= 1'b0;
    end else begin
      if (f_we && fa == 0) cnt_f2h <= f_wdata;
      if (h_we && ha == 1) cnt_h2f <= h_wdata;
      if (h_we && ha == MASK_A) irq_mask <= h_wdata;
      if (h_ctl_wr) begin h_hold <= h_grab; h_req <= h_wdata[0]; end
      if (f_ctl_wr) begin f_hold <= f_grab; f_req <= f_wdata[0]; end
      h_evt <= h_ctl_wr && h_wdata[0];
      f_evt <= f_ctl_wr && f_wdata[0];
      if (h_we && h_hold && ha == BUF0) buf_consumed <= 1'b1;
      else if (f_buf_wr)                buf_consumed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_WORDS; i++) buf_q[i] <= '0;
    end else begin
      for (int i = 0; i < BUF_WORDS; i++) begin
        if (h_we && h_hold && ha == BUF0 + i)      buf_q[i] <= h_wdata;
        else if (f_we && f_hold && fa == BUF0 + i) buf_q[i] <= f_wdata;
      end
    end
  end

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 0)           v = cnt_f2h;
    else if (a == 1)      v = cnt_h2f;
    else if (a == CTL_H)  v = {28'd0, h_hold, 2'b00, h_req};
    else if (a == CTL_F)  v = {28'd0, f_hold, 2'b00, f_req};
    else if (a == MASK_A) v = irq_mask;
    else
      for (int i = 0; i < BUF_WORDS; i++)
        if (a == BUF0 + i) v = buf_q[i];
    return v;
  endfunction

  logic [31:0] h_rd_c, f_rd_c;
  always_comb h_rd_c = rd_word(ha);
  always_comb f_rd_c = rd_word(fa);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rdata <= '0; f_rdata <= '0;
    end else begin
      h_rdata <= h_rd_c; f_rdata <= f_rd_c;
    end
  end

  a_r2_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ctl_wr && h_wdata[3] && !f_hold && !mbx_clr) |=> h_hold);
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ctl_wr && h_wdata == 32'd0) |=> (!h_hold && !h_req));
  a_r3_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_hold && f_hold));
  a_r3_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (f_ctl_wr && f_wdata[3] && h_hold) |=> !f_hold);
  a_r6_fw_event: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ctl_wr && h_wdata[0] && !irq_mask[0] && !mbx_clr) |=> fw_irq);
  a_r7_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_hold && ha == BUF0 && !mbx_clr) |=> buf_consumed);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_clr |=> (cnt_f2h == 0 && cnt_h2f == 0 && irq_mask == MASK_INIT
                 && !h_hold && !f_hold && !buf_consumed));
endmodule

// File: tb/test_shm_mailbox.sv
`timescale 1ns/1ps
module test_shm_mailbox;
  logic clk = 1'b0, rst_n = 1'b0, mbx_clr = 1'b0;
  logic h_we = 1'b0, f_we = 1'b0;
  logic [4:0] h_addr = '0, f_addr = '0;
  logic [31:0] h_wdata = '0, f_wdata = '0, h_rdata, f_rdata;
  logic fw_irq, host_irq, buf_consumed;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shm_mailbox i_shm_mailbox (
    .clk(clk), .rst_n(rst_n), .mbx_clr(mbx_clr),
    .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .f_we(f_we), .f_addr(f_addr), .f_wdata(f_wdata), .f_rdata(f_rdata),
    .fw_irq(fw_irq), .host_irq(host_irq), .buf_consumed(buf_consumed));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input int a, input logic [31:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = 5'(a); h_wdata = d;
    @(negedge clk); h_we = 1'b0;
  endtask
  task automatic fw(input int a, input logic [31:0] d);
    @(negedge clk); f_we = 1'b1; f_addr = 5'(a); f_wdata = d;
    @(negedge clk); f_we = 1'b0;
  endtask
  task automatic both(input int ah, input logic [31:0] dh, input int af, input logic [31:0] df);
    @(negedge clk); h_we = 1'b1; h_addr = 5'(ah); h_wdata = dh;
    f_we = 1'b1; f_addr = 5'(af); f_wdata = df;
    @(negedge clk); h_we = 1'b0; f_we = 1'b0;
  endtask
  task automatic hr(input int a, output logic [31:0] v);
    @(negedge clk); h_addr = 5'(a);
    @(negedge clk); v = h_rdata;
  endtask
  task automatic fr(input int a, output logic [31:0] v);
    @(negedge clk); f_addr = 5'(a);
    @(negedge clk); v = f_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] mb [14];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R9 unmapped reads
    for (int a = 0; a < 32; a++) begin
      hr(a, v);
      chk($sformatf("R1/R9 reset word %0d", a), v, (a == 18) ? 32'hFFFF_0000 : 32'd0);
    end
    chk("R1 fw_irq", {31'd0, fw_irq}, 0);
    chk("R1 host_irq", {31'd0, host_irq}, 0);
    chk("R1 buf_consumed", {31'd0, buf_consumed}, 0);
    for (int i = 0; i < 14; i++) mb[i] = 32'd0;

    // R4 counter ownership
    hw(0, 32'h1111_2222);
    fw(0, 32'h0003_0005);
    hw(1, 32'h0001_0002);
    fw(1, 32'h7777_8888);
    hr(0, v); chk("R4 word0 host view", v, 32'h0003_0005);
    fr(0, v); chk("R4 word0 fw view", v, 32'h0003_0005);
    hr(1, v); chk("R4 word1 host view", v, 32'h0001_0002);
    fr(1, v); chk("R4 word1 fw view", v, 32'h0001_0002);

    // R5 no holder: every buffer write ignored
    for (int i = 0; i < 14; i++) begin
      hw(2 + i, 32'hA000_0000 + i);
      fw(2 + i, 32'hB000_0000 + i);
    end
    for (int i = 0; i < 14; i++) begin
      hr(2 + i, v); chk($sformatf("R5 free word %0d", i), v, mb[i]);
    end
    chk("R7 no holder no flag", {31'd0, buf_consumed}, 0);

    // R2 host takes the lock, R3 firmware denied
    hw(16, 32'h8);
    hr(16, v); chk("R2 host hold readback", v, 32'h8);
    fw(17, 32'h8);
    fr(17, v); chk("R3 fw denied readback", v, 32'h0);

    // R5 host owns: host writes land, firmware writes dropped
    for (int i = 1; i < 14; i++) begin
      hw(2 + i, 32'h1000_0000 + i * 32'h0101);
      mb[i] = 32'h1000_0000 + i * 32'h0101;
      fw(2 + i, 32'hDEAD_0000 + i);
    end
    chk("R7 other words keep flag low", {31'd0, buf_consumed}, 0);
    hw(2, 32'h1000_0000); mb[0] = 32'h1000_0000;
    chk("R7 first word sets flag", {31'd0, buf_consumed}, 1);
    for (int i = 0; i < 14; i++) begin
      fr(2 + i, v); chk($sformatf("R5 host-owned word %0d", i), v, mb[i]);
    end

    // R6 host request event
    hw(16, 32'h9);
    chk("R6 fw_irq pulse", {31'd0, fw_irq}, 1);
    @(negedge clk);
    chk("R6 fw_irq one cycle", {31'd0, fw_irq}, 0);
    hr(16, v); chk("R2 hold+req readback", v, 32'h9);
    hw(16, 32'h0);
    chk("R6 no event without req", {31'd0, fw_irq}, 0);
    hr(16, v); chk("R2 release clears", v, 32'h0);

    // R2/R3 firmware owns
    fw(17, 32'h8);
    fr(17, v); chk("R2 fw hold readback", v, 32'h8);
    hw(16, 32'h8);
    hr(16, v); chk("R3 host denied readback", v, 32'h0);
    hw(3, 32'h5555_5555);
    hr(3, v); chk("R5 host write dropped", v, mb[1]);
    chk("R7 flag held before fw write", {31'd0, buf_consumed}, 1);
    fw(7, 32'hCAFE_0007); mb[5] = 32'hCAFE_0007;
    chk("R7 fw write clears flag", {31'd0, buf_consumed}, 0);
    for (int i = 0; i < 14; i++) begin
      hr(2 + i, v); chk($sformatf("R5 fw-owned word %0d", i), v, mb[i]);
    end

    // R6 firmware request toward host, masked by bit 16
    fw(17, 32'h9);
    chk("R6 host_irq masked", {31'd0, host_irq}, 0);
    fw(18, 32'h0);
    fr(18, v); chk("R6 fw mask write ignored", v, 32'hFFFF_0000);
    hw(18, 32'h0);
    fw(17, 32'h9);
    chk("R6 host_irq unmasked", {31'd0, host_irq}, 1);
    hw(18, 32'h1);
    fw(17, 32'h0);
    hw(16, 32'h9);
    chk("R6 fw_irq masked", {31'd0, fw_irq}, 0);
    hw(16, 32'h0);

    // R3 simultaneous grab: host wins
    both(16, 32'h8, 17, 32'h8);
    hr(16, v); chk("R3 tie host wins", v, 32'h8);
    fr(17, v); chk("R3 tie fw loses", v, 32'h0);
    hw(2, 32'h0); mb[0] = 32'h0;
    chk("R7 consumed again", {31'd0, buf_consumed}, 1);

    // R8 mailbox reset command
    @(negedge clk); mbx_clr = 1'b1;
    @(negedge clk); mbx_clr = 1'b0;
    hr(0, v);  chk("R8 word0 cleared", v, 0);
    hr(1, v);  chk("R8 word1 cleared", v, 0);
    hr(16, v); chk("R8 host ctl cleared", v, 0);
    fr(17, v); chk("R8 fw ctl cleared", v, 0);
    fr(18, v); chk("R8 mask reloaded", v, 32'hFFFF_0000);
    chk("R8 flag cleared", {31'd0, buf_consumed}, 0);
    for (int i = 0; i < 14; i++) begin
      fr(2 + i, v); chk($sformatf("R8 buffer kept %0d", i), v, mb[i]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule